// File: doc/BRIEF.md
# Scan-Cycle Logic Controller

This block drives a small programmable controller through a fixed, repeating scan. Each scan begins with a supervision step that restarts a watchdog. It then takes one snapshot of all input pins and evaluates a short list of Boolean rules held in on-chip program memory. The rules read only the snapshot and a shadow copy of the outputs, and they write only that shadow copy. The scan ends by copying the shadow to the output pins in a single clock edge. A programmable period sets how often a scan may start. A run/program input parks the block idle with all outputs off. While it is parked, a write port fills the program memory.

Each program word is one rule. The rule selects one output bit and has up to four contacts. The contacts are ANDed, and each contact can read an input bit or an output-image bit, inverted or not. Rules run one per clock from address 0 upward. A later rule that targets the same output bit overrides an earlier one. If a scan fails to come back to its supervision step in time, the block enters a fault state: it clears the outputs and stays halted until reset.

Top module: `scan_ctrl`

## Requirements
- R1: While rst_ni is low, out_o, running_o and fault_o are 0, the output image is cleared and program memory is emptied (all-zero words).
- R2: While run_i is 0 and no fault is present, the block idles: one edge later out_o is 0 and running_o is 0. In this state a high prog_we_i writes prog_data_i to prog_addr_i.
- R3: A write on the program port while run_i is 1 is ignored, and the stored program is unchanged.
- R4: Inputs are sampled at one edge per scan: the third rising edge after run_i rises, then every period_i edges after that. A pulse that lies wholly between two sample edges never reaches out_o. A pulse that spans a sample edge reaches out_o within that scan.
- R5: Rule word layout (N_IO=8): bits [26:24] give the target output index. Contact c occupies bits [6c+5:6c], with bit 5 = enable, bit 4 = source (0 input snapshot, 1 output image), bit 3 = invert and bits [2:0] = index. The result is the AND of (bit XOR invert) over the enabled contacts, and is 1 when no contact is enabled.
- R6: Rules run in address order. A contact with source 1 sees the value an earlier rule wrote to the output image in the same scan.
- R7: When two rules target the same output bit, out_o carries the value from the rule at the higher address.
- R8: Evaluation stops at the first all-zero word, and words stored after it have no effect. A program that fills every address has all of its rules evaluated, including the last one.
- R9: out_o changes only on the edge that ends the output phase, when all bits are copied from the image together, or when out_o is forced to zero.
- R10: If no new scan starts within WDT_LIMIT cycles of the last supervision step, fault_o rises, out_o goes to 0, and the block stays halted whatever run_i does until reset.
- R11: running_o is 1 while scanning and 0 when idle or faulted. fault_o and running_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 = scan, 0 = program/idle |
| period_i | input | PERIOD_W | Minimum cycles from one scan start to the next |
| in_i | input | N_IO | Physical input pins |
| prog_we_i | input | 1 | Program memory write strobe |
| prog_addr_i | input | clog2(PROG_DEPTH) | Program memory write address |
| prog_data_i | input | IDX_W+4*(IDX_W+3) | Rule word to store |
| out_o | output | N_IO | Physical output pins |
| running_o | output | 1 | Scan in progress |
| fault_o | output | 1 | Watchdog fault |

## Verification
The input snapshot is taken on the third edge after run_i rises and every period_i edges after that. out_o follows n+2 edges after the snapshot for a program of n rules that ends in a zero word. To stay clear of these edges, functional checks hold the inputs steady for two full periods plus margin before they sample out_o at a falling edge. The pulse test counts edges from the rise of run_i. It places one pulse entirely between snapshots and checks out_o on every falling edge for two periods. It then places a second pulse across the snapshot at edge 83, samples at edge 100, and checks again at edge 130, after the next snapshot has cleared the value. The fault check samples well past WDT_LIMIT, and the reset check samples 1 ns after rst_ni falls.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned CONTACTS = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TEST,
    PH_IN,
    PH_LOGIC,
    PH_OUT,
    PH_WAIT,
    PH_FAULT
  } phase_e;
endpackage

// File: rtl/scan_prog_mem.sv
module scan_prog_mem #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 27,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/scan_rung_eval.sv
module scan_rung_eval
  import scan_pkg::*;
#(
  parameter int unsigned N_IO  = 8,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned CW     = IDX_W + 3,
  localparam int unsigned WORD_W = IDX_W + CONTACTS * CW,
  localparam int unsigned SPAN   = 1 << IDX_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [N_IO-1:0]   in_img_i,
  input  logic [N_IO-1:0]   out_img_i,
  output logic [IDX_W-1:0]  dst_o,
  output logic              res_o
);
  logic [SPAN-1:0]     in_pad, out_pad;
  logic [CONTACTS-1:0] term;

  assign in_pad  = SPAN'(in_img_i);
  assign out_pad = SPAN'(out_img_i);

  for (genvar c = 0; c < CONTACTS; c++) begin : g_contact
    logic [CW-1:0]    ct;
    logic [IDX_W-1:0] idx;
    logic             bit_v;
    assign ct    = word_i[c*CW +: CW];
    assign idx   = ct[IDX_W-1:0];
    assign bit_v = ct[IDX_W+1] ? out_pad[idx] : in_pad[idx];
    // disabled contact passes as closed
    assign term[c] = !ct[IDX_W+2] || (bit_v ^ ct[IDX_W]);
  end

  assign res_o = &term;
  assign dst_o = word_i[WORD_W-1 -: IDX_W];
endmodule

// File: rtl/scan_wdt.sv
module scan_wdt #(
  parameter int unsigned LIMIT = 256,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (cnt_q != CNT_W'(LIMIT)) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expired_o = (cnt_q == CNT_W'(LIMIT));
endmodule

// File: rtl/scan_period_timer.sv
module scan_period_timer #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                elapsed_o
);
  logic [PERIOD_W-1:0] cnt_q;

  // restart loads 1 so the count equals cycles since the scan began
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (restart_i)     cnt_q <= PERIOD_W'(1);
    else if (cnt_q != '1)   cnt_q <= cnt_q + PERIOD_W'(1);
  end

  assign elapsed_o = ({1'b0, cnt_q} + (PERIOD_W+1)'(1)) >= {1'b0, period_i};
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int unsigned N_IO       = 8,
  parameter int unsigned PROG_DEPTH = 16,
  parameter int unsigned WDT_LIMIT  = 256,
  parameter int unsigned PERIOD_W   = 16,
  localparam int unsigned IDX_W  = (N_IO > 1) ? $clog2(N_IO) : 1,
  localparam int unsigned CW     = IDX_W + 3,
  localparam int unsigned WORD_W = IDX_W + CONTACTS * CW,
  localparam int unsigned AW     = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [N_IO-1:0]     in_i,
  input  logic                prog_we_i,
  input  logic [AW-1:0]       prog_addr_i,
  input  logic [WORD_W-1:0]   prog_data_i,
  output logic [N_IO-1:0]     out_o,
  output logic                running_o,
  output logic                fault_o
);
  localparam int unsigned SPAN = 1 << IDX_W;

  phase_e            state_q;
  logic [N_IO-1:0]   in_img_q, out_img_q, out_q;
  logic [AW-1:0]     pc_q;
  logic [WORD_W-1:0] rung_word;
  logic [IDX_W-1:0]  dst;
  logic              res, dst_ok, wdt_expired, period_done;

  scan_prog_mem #(.DEPTH(PROG_DEPTH), .WIDTH(WORD_W)) i_mem (
    .clk_i, .rst_ni,
    .we_i    (prog_we_i && !run_i),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (pc_q),
    .rdata_o (rung_word)
  );

  scan_rung_eval #(.N_IO(N_IO), .IDX_W(IDX_W)) i_eval (
    .word_i    (rung_word),
    .in_img_i  (in_img_q),
    .out_img_i (out_img_q),
    .dst_o     (dst),
    .res_o     (res)
  );

  scan_wdt #(.LIMIT(WDT_LIMIT)) i_wdt (
    .clk_i, .rst_ni,
    .clear_i   (state_q == PH_TEST || state_q == PH_IDLE),
    .expired_o (wdt_expired)
  );

  scan_period_timer #(.PERIOD_W(PERIOD_W)) i_period (
    .clk_i, .rst_ni,
    .restart_i (state_q == PH_TEST),
    .period_i,
    .elapsed_o (period_done)
  );

  if (N_IO == SPAN) begin : g_dst_full
    assign dst_ok = 1'b1;
  end else begin : g_dst_part
    assign dst_ok = ({1'b0, dst} < (IDX_W+1)'(N_IO));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PH_IDLE;
      in_img_q  <= '0;
      out_img_q <= '0;
      out_q     <= '0;
      pc_q      <= '0;
    end else if (state_q == PH_FAULT) begin
      out_q <= '0;
    end else if (wdt_expired) begin
      state_q <= PH_FAULT;
      out_q   <= '0;
    end else if (!run_i) begin
      state_q   <= PH_IDLE;
      out_q     <= '0;
      out_img_q <= '0;
    end else begin
      unique case (state_q)
        PH_IDLE: state_q <= PH_TEST;
        PH_TEST: state_q <= PH_IN;
        PH_IN: begin
          in_img_q <= in_i;
          pc_q     <= '0;
          state_q  <= PH_LOGIC;
        end
        PH_LOGIC: begin
          if (rung_word == '0) begin
            state_q <= PH_OUT;
          end else begin
            if (dst_ok) out_img_q[dst] <= res;
            if (pc_q == AW'(PROG_DEPTH - 1)) state_q <= PH_OUT;
            else                              pc_q    <= pc_q + AW'(1);
          end
        end
        PH_OUT: begin
          out_q   <= out_img_q;
          state_q <= PH_WAIT;
        end
        PH_WAIT: if (period_done) state_q <= PH_TEST;
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign out_o     = out_q;
  assign running_o = (state_q != PH_IDLE) && (state_q != PH_FAULT);
  assign fault_o   = (state_q == PH_FAULT);
endmodule

// File: rtl/scan_ctrl_chk.sv
module scan_ctrl_chk
  import scan_pkg::*;
#(
  parameter int unsigned N_IO = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            run_i,
  input logic [N_IO-1:0] out_o,
  input logic            running_o,
  input logic            fault_o,
  input phase_e          state_i,
  input logic [N_IO-1:0] in_img_i
);
  a_r10_fault_outputs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> out_o == '0);

  a_r10_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  a_r2_program_mode_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !fault_o) |=> (out_o == '0 && !running_o));

  a_r9_outputs_move_in_out_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_o) |-> ($past(state_i) == PH_OUT || out_o == '0));

  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && running_o));

  a_r4_snapshot_in_input_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(in_img_i) |-> $past(state_i) == PH_IN);
endmodule

bind scan_ctrl scan_ctrl_chk #(.N_IO(N_IO)) i_scan_ctrl_chk (
  .clk_i, .rst_ni, .run_i, .out_o, .running_o, .fault_o,
  .state_i  (state_q),
  .in_img_i (in_img_q)
);

// File: tb/test_scan_ctrl.sv
module test_scan_ctrl;
  localparam int N_IO = 8, DEPTH = 16, WDT = 256, PW = 16;
  localparam int IDX_W = 3, CW = 6, WORD_W = 27, AW = 4;
  localparam int P = 40, SETTLE = 2 * P + 10;

  logic              clk = 1'b0, rst_ni = 1'b0, run_i = 1'b0, prog_we = 1'b0;
  logic [PW-1:0]     period = PW'(P);
  logic [N_IO-1:0]   in_i = '0, out_o;
  logic [AW-1:0]     prog_addr = '0;
  logic [WORD_W-1:0] prog_data = '0;
  logic              running_o, fault_o;

  int n_checks = 0, n_errs = 0;
  bit done = 0;
  logic [WORD_W-1:0] prog_m [DEPTH];
  int prog_n = 0;

  scan_ctrl #(.N_IO(N_IO), .PROG_DEPTH(DEPTH), .WDT_LIMIT(WDT), .PERIOD_W(PW)) i_scan_ctrl (
    .clk_i(clk), .rst_ni, .run_i, .period_i(period), .in_i,
    .prog_we_i(prog_we), .prog_addr_i(prog_addr), .prog_data_i(prog_data),
    .out_o, .running_o, .fault_o
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: run hung (all requirements) actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  function automatic logic [CW-1:0] ct(bit en, bit src, bit inv, int idx);
    return {en, src, inv, IDX_W'(idx)};
  endfunction

  function automatic logic [WORD_W-1:0] rung(int dst, logic [CW-1:0] c0, c1, c2, c3);
    return {IDX_W'(dst), c3, c2, c1, c0};
  endfunction

  function automatic logic [N_IO-1:0] model(logic [N_IO-1:0] pins);
    logic [N_IO-1:0] img = '0;
    for (int r = 0; r < prog_n; r++) begin
      logic [WORD_W-1:0] w = prog_m[r];
      logic acc = 1'b1;
      if (w == '0) break;
      for (int c = 0; c < 4; c++) begin
        logic [CW-1:0] k = w[c*CW +: CW];
        if (k[5]) acc &= (k[4] ? img[k[2:0]] : pins[k[2:0]]) ^ k[3];
      end
      img[w[WORD_W-1 -: IDX_W]] = acc;
    end
    return img;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [N_IO-1:0] act, logic [N_IO-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_prog();
    run_i = 1'b0;
    cyc(2);
    for (int i = 0; i < prog_n; i++) begin
      prog_we = 1'b1; prog_addr = AW'(i); prog_data = prog_m[i];
      cyc(1);
    end
    if (prog_n < DEPTH) begin
      prog_we = 1'b1; prog_addr = AW'(prog_n); prog_data = '0;
      cyc(1);
    end
    prog_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    cyc(3);
    chk("R1 out_o in reset", out_o, '0);
    chk("R1 flags in reset", {6'b0, running_o, fault_o}, '0);
    rst_ni = 1'b1;
    cyc(2);
    chk("R2 idle after reset", {6'b0, running_o, fault_o}, '0);

    // directed program: R5 R6 R7
    prog_m[0] = rung(0, ct(1,0,0,0), ct(1,0,1,1), '0, '0);
    prog_m[1] = rung(0, ct(1,0,0,2), '0, '0, '0);
    prog_m[2] = rung(1, ct(1,1,0,0), '0, '0, '0);
    prog_m[3] = rung(2, '0, '0, '0, '0);
    prog_m[4] = rung(3, ct(1,0,0,4), ct(1,0,0,5), ct(1,0,0,6), ct(1,0,1,7));
    prog_m[5] = rung(7, '0, '0, '0, '0);
    prog_m[6] = rung(6, '0, '0, '0, '0);
    prog_n = 7;
    load_prog();
    prog_n = 5;
    load_prog();
    run_i = 1'b1;
    cyc(3);
    chk("R11 running_o while scanning", {7'b0, running_o}, 8'h01);
    foreach (prog_m[i]) if (i >= 5) prog_m[i] = '0;
    begin
      logic [N_IO-1:0] pats [4] = '{8'h71, 8'h05, 8'hF4, 8'h72};
      foreach (pats[p]) begin
        in_i = pats[p];
        cyc(SETTLE);
        chk("R5 R6 R7 directed rules", out_o, model(pats[p]));
        chk("R7 later rule overrides", {7'b0, out_o[0]}, {7'b0, pats[p][2]});
        chk("R6 output-image contact", {7'b0, out_o[1]}, {7'b0, out_o[0]});
        chk("R8 words after end marker ignored", out_o[7:6], 2'b00);
      end
    end
    chk("R5 four-contact rule", {7'b0, out_o[3]}, 8'h01);
    chk("R5 contactless rule is 1", {7'b0, out_o[2]}, 8'h01);

    // R2: program mode forces outputs off
    run_i = 1'b0;
    cyc(2);
    chk("R2 outputs off in program mode", out_o, '0);
    chk("R2 running_o low in program mode", {7'b0, running_o}, '0);

    // R8: full-depth program, last address evaluated
    for (int i = 0; i < DEPTH; i++) prog_m[i] = rung(i % 6, ct(1,0,0,i % 8), '0, '0, '0);
    prog_m[DEPTH-1] = rung(6, ct(1,0,1,0), '0, '0, '0);
    prog_n = DEPTH;
    load_prog();
    in_i = 8'hA6;
    run_i = 1'b1;
    cyc(SETTLE);
    chk("R8 full program incl last address", out_o, model(8'hA6));

    // R3: writes during run ignored
    prog_m[0] = rung(0, ct(1,0,0,0), '0, '0, '0);
    prog_n = 1;
    load_prog();
    in_i = 8'h01;
    run_i = 1'b1;
    cyc(SETTLE);
    chk("R3 baseline", out_o, 8'h01);
    prog_we = 1'b1; prog_addr = '0; prog_data = rung(0, ct(1,0,1,0), '0, '0, '0);
    cyc(1);
    prog_we = 1'b0;
    cyc(SETTLE);
    chk("R3 write during run ignored", out_o, 8'h01);
    run_i = 1'b0;
    cyc(2);
    run_i = 1'b1;
    cyc(SETTLE);
    chk("R3 stored program unchanged", out_o, 8'h01);

    // R4: snapshot timing and pulses between snapshots
    run_i = 1'b0;
    in_i = '0;
    cyc(2);
    run_i = 1'b1;
    cyc(12);
    in_i = 8'h01;
    cyc(10);
    in_i = '0;
    begin
      bit seen = 0;
      for (int e = 22; e < 80; e++) begin
        cyc(1);
        if (out_o !== '0) seen = 1;
      end
      chk("R4 pulse between snapshots not seen", {7'b0, seen}, '0);
    end
    in_i = 8'h01;
    cyc(5);
    in_i = '0;
    cyc(15);
    chk("R4 pulse across snapshot seen", out_o, 8'h01);
    cyc(30);
    chk("R4 next snapshot clears it", out_o, '0);

    // random programs: R5 R8
    for (int it = 0; it < 10; it++) begin
      prog_n = 1 + int'($urandom_range(DEPTH - 1));
      for (int r = 0; r < prog_n; r++) begin
        logic [CW-1:0] c [4];
        for (int k = 0; k < 4; k++)
          c[k] = ct((k == 0) || $urandom_range(1) == 1, 1'b0, $urandom_range(1) == 1,
                    int'($urandom_range(7)));
        prog_m[r] = rung(int'($urandom_range(7)), c[0], c[1], c[2], c[3]);
      end
      load_prog();
      in_i = N_IO'($urandom);
      run_i = 1'b1;
      cyc(SETTLE);
      chk("R5 R8 random program", out_o, model(in_i));
      in_i = N_IO'($urandom);
      cyc(SETTLE);
      chk("R5 random inputs", out_o, model(in_i));
    end

    // R10: watchdog fault
    prog_m[0] = rung(2, '0, '0, '0, '0);
    prog_n = 1;
    load_prog();
    period = PW'(600);
    run_i = 1'b1;
    cyc(30);
    chk("R10 outputs before timeout", out_o, 8'h04);
    chk("R10 no fault before timeout", {7'b0, fault_o}, '0);
    cyc(400);
    chk("R10 fault raised", {7'b0, fault_o}, 8'h01);
    chk("R10 outputs off on fault", out_o, '0);
    chk("R11 running_o low on fault", {7'b0, running_o}, '0);
    run_i = 1'b0;
    cyc(5);
    run_i = 1'b1;
    cyc(5);
    chk("R10 fault sticky", {7'b0, fault_o}, 8'h01);

    // R1: reset while outputs on
    rst_ni = 1'b0;
    #1;
    chk("R1 reset clears fault", {7'b0, fault_o}, '0);
    period = PW'(P);
    cyc(2);
    rst_ni = 1'b1;
    prog_m[0] = rung(1, '0, '0, '0, '0);
    load_prog();
    run_i = 1'b1;
    cyc(SETTLE);
    chk("R1 setup outputs on", out_o, 8'h02);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset clears outputs", out_o, '0);
    cyc(2);
    rst_ni = 1'b1;
    cyc(SETTLE);
    chk("R1 program memory emptied", out_o, '0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule